// File: doc/BRIEF.md
# Write-Protected Fractional PLL Register Bank

This block is the register file that sits between a simple 32-bit memory-mapped bus and a fractional PLL. It keeps the control word, the integer and fractional feedback divider settings, the reference divider word, a read-only configuration word and up to sixteen output-divider control words. It also carries a small behavioural model of loop acquisition that drives the lock flag in the status word.

Configuration is protected by a two-key unlock. Until the first key word has been written to its key register and then the second key word to its own key register, every other bus write is silently discarded. A wrong value in either key register throws the bank back to the protected state. Reads are always allowed. They return data one cycle after the read strobe, and zero for any offset that holds no register.

Lock is modelled as a fixed settling delay. The count starts once the PLL is enabled with bypass clear. The flag clears at once when bypass is set or the enable is removed. It also clears, and the count starts over, when either feedback divider register accepts a write.

Top module: `pll_ctl_regs`

## Requirements
- R1: After reset the control word (byte offset 0x20) reads 0x80000000, which means bypass is on and the PLL is off. The status word (0x24), the feedback divider words (0x30, 0x34), the reference divider word (0x38) and every present output-divider word read 0.
- R2: Writes to any register except the two key registers are dropped until 0x68EF3490 has been written to offset 0x10 and then 0xD172BC5A to offset 0x14. After that sequence, writes take effect in the same clock edge.
- R3: Any other value written to either key register returns the bank to the protected state. A correct second key with no correct first key before it does not unlock the bank. A correct first key written while the bank is unlocked leaves it unlocked.
- R4: The control word keeps only bit 31 (bypass), bit 15 (PLL enable) and bit 1 (delta-sigma enable). All other bits read 0.
- R5: Offset 0x30 keeps the low 12 bits and offset 0x34 keeps the low 24 bits. All other bits read 0. Offset 0x38 keeps all 32 bits: the reference divider in bits 5:0 and the other divider fields above it.
- R6: The configuration word at 0x08 always reads the CFG_RESET parameter, and writes to it have no effect. Bit 16+i of that word marks output divider i as present.
- R7: Output divider i sits at byte offset 0x80+4*i. When present, it keeps bit 15 (output enable) and the low DIV_W bits (divide value). An absent divider reads 0 and ignores writes.
- R8: Reads of offsets that hold no register, including offsets that are not word aligned, return 0. The two key registers also read 0.
- R9: Suppose the write that enables the PLL with bypass clear lands at clock edge E0. Then a status read whose strobe is sampled at edge E0+LOCK_CYC returns bit 0 = 0, and one sampled at E0+LOCK_CYC+1 returns 1.
- R10: Once bypass is set or the enable is cleared, the very next status read returns 0. After the PLL is re-enabled, the R9 delay starts over.
- R11: An accepted write to 0x30 or 0x34 clears lock and restarts the R9 delay from that write's edge. The same write dropped while the bank is protected leaves lock set.
- R12: Read data appears on the clock edge that samples the read strobe and is held until the next edge. Read data is 0 in any cycle after an edge with no read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |

## Verification
Directed sequences check the key logic against each failure mode it must tell apart: a correct unlock, keys written in the wrong order, a bad first key and a bad second key, each followed by a probe write to the control word. Lock timing is polled one read per cycle after three different triggers, which are enable, re-enable after bypass and a feedback divider write. These checks separate an off-by-one settling delay from a correct one, and a drop that comes one cycle late from an immediate one. A seeded random stream of writes and read-backs then covers every mapped, masked, absent and unmapped offset. It exposes wrong field masks, decode aliasing and writes that touch the wrong output-divider slot.

// File: rtl/pll_ctl_pkg.sv
package pll_ctl_pkg;
  localparam logic [7:0] OFF_CFG   = 8'h08;
  localparam logic [7:0] OFF_KEY_A = 8'h10;
  localparam logic [7:0] OFF_KEY_B = 8'h14;
  localparam logic [7:0] OFF_CTRL  = 8'h20;
  localparam logic [7:0] OFF_STAT  = 8'h24;
  localparam logic [7:0] OFF_FBI   = 8'h30;
  localparam logic [7:0] OFF_FBF   = 8'h34;
  localparam logic [7:0] OFF_DIV   = 8'h38;
  localparam logic [7:0] OFF_OD    = 8'h80;

  localparam logic [31:0] KEY_A = 32'h68EF_3490;
  localparam logic [31:0] KEY_B = 32'hD172_BC5A;

  localparam int CTRL_BYP = 31;
  localparam int CTRL_EN  = 15;
  localparam int CTRL_DSM = 1;
  localparam logic [31:0] CTRL_MASK = 32'h8000_8002;
  localparam logic [31:0] CTRL_RST  = 32'h8000_0000;

  localparam int FBI_W = 12;
  localparam int FBF_W = 24;
  localparam int OD_EN_BIT = 15;

  typedef enum logic [1:0] {KS_SHUT, KS_HALF, KS_OPEN} key_state_e;
endpackage

// File: rtl/pll_unlock_fsm.sv
module pll_unlock_fsm
  import pll_ctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        key_a_wr,
  input  logic        key_b_wr,
  input  logic [31:0] wdata,
  output logic        open_o
);
  key_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (key_a_wr) begin
      if (wdata != KEY_A)          state_d = KS_SHUT;
      else if (state_q != KS_OPEN) state_d = KS_HALF;
    end else if (key_b_wr) begin
      if (wdata != KEY_B)          state_d = KS_SHUT;
      else if (state_q == KS_HALF) state_d = KS_OPEN;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= KS_SHUT;
    else     state_q <= state_d;
  end

  assign open_o = (state_q == KS_OPEN);

  p_open_after_key_b_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(open_o) |-> $past(key_b_wr && wdata == KEY_B));

  p_bad_key_shuts_r3: assert property (@(posedge clk) disable iff (rst)
    ((key_a_wr && wdata != KEY_A) || (key_b_wr && wdata != KEY_B)) |=> !open_o);
endmodule

// File: rtl/pll_lock_model.sv
module pll_lock_model #(
  parameter int LOCK_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic pll_en,
  input  logic bypass,
  input  logic restart,
  output logic lock_o
);
  localparam int CW = $clog2(LOCK_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(LOCK_CYC - 1);

  logic          run;
  logic [CW-1:0] cnt_q;
  logic          lock_q;

  assign run = pll_en && !bypass;

  always_ff @(posedge clk) begin
    if (rst || !run || restart) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else if (cnt_q == LAST) begin
      lock_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign lock_o = lock_q && run;

  p_lock_after_count_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_q) |-> $past(cnt_q) == LAST);

  p_restart_clears_r11: assert property (@(posedge clk) disable iff (rst)
    restart |=> !lock_q);
endmodule

// File: rtl/pll_outdiv_bank.sv
module pll_outdiv_bank
  import pll_ctl_pkg::*;
#(
  parameter int NUM_OUT = 16,
  parameter int DIV_W   = 6,
  parameter logic [NUM_OUT-1:0] PRESENT = '1,
  localparam int IW = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [31:0]   wdata,
  input  logic [IW-1:0] rd_idx,
  output logic [31:0]   rd_val
);
  localparam logic [31:0] OD_MASK = (32'h1 << OD_EN_BIT) | ((32'h1 << DIV_W) - 32'h1);

  logic [31:0] slot [NUM_OUT];

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_slot
    if (PRESENT[i]) begin : g_here
      always_ff @(posedge clk) begin
        if (rst)                                slot[i] <= '0;
        else if (wr_en && wr_idx == IW'(i))     slot[i] <= wdata & OD_MASK;
      end
    end else begin : g_absent
      assign slot[i] = '0;
    end
  end

  assign rd_val = (32'(rd_idx) < NUM_OUT) ? slot[rd_idx] : '0;
endmodule

// File: rtl/pll_ctl_regs.sv
module pll_ctl_regs
  import pll_ctl_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NUM_OUT  = 16,
  parameter int DIV_W    = 6,
  parameter int LOCK_CYC = 16,
  parameter logic [31:0] CFG_RESET = 32'h00A5_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [31:0]       bus_rdata
);
  localparam int IW = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1;
  localparam logic [NUM_OUT-1:0] PRESENT = CFG_RESET[16 +: NUM_OUT];
  localparam logic [ADDR_W-1:0] OD_LO = ADDR_W'(OFF_OD);
  localparam logic [ADDR_W-1:0] OD_HI = ADDR_W'(OFF_OD + 4 * NUM_OUT);

  logic hit_cfg, hit_ka, hit_kb, hit_ctrl, hit_stat, hit_fbi, hit_fbf, hit_div, hit_od;
  logic [ADDR_W-1:0] od_off;
  logic [IW-1:0]     od_idx;
  logic              open, wr_ok, lock;
  logic [31:0]       ctrl_q, div_q, od_rd, rd_val, rdata_q;
  logic [FBI_W-1:0]  fbi_q;
  logic [FBF_W-1:0]  fbf_q;

  assign hit_cfg  = bus_addr == ADDR_W'(OFF_CFG);
  assign hit_ka   = bus_addr == ADDR_W'(OFF_KEY_A);
  assign hit_kb   = bus_addr == ADDR_W'(OFF_KEY_B);
  assign hit_ctrl = bus_addr == ADDR_W'(OFF_CTRL);
  assign hit_stat = bus_addr == ADDR_W'(OFF_STAT);
  assign hit_fbi  = bus_addr == ADDR_W'(OFF_FBI);
  assign hit_fbf  = bus_addr == ADDR_W'(OFF_FBF);
  assign hit_div  = bus_addr == ADDR_W'(OFF_DIV);
  assign hit_od   = (bus_addr[1:0] == 2'b00) && (bus_addr >= OD_LO) && (bus_addr < OD_HI);
  assign od_off   = bus_addr - OD_LO;
  assign od_idx   = od_off[IW+1:2];

  pll_unlock_fsm u_keys (
    .clk(clk), .rst(rst),
    .key_a_wr(bus_we && hit_ka), .key_b_wr(bus_we && hit_kb),
    .wdata(bus_wdata), .open_o(open)
  );

  assign wr_ok = bus_we && open;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_RST;
      fbi_q  <= '0;
      fbf_q  <= '0;
      div_q  <= '0;
    end else if (wr_ok) begin
      if (hit_ctrl) ctrl_q <= bus_wdata & CTRL_MASK;
      if (hit_fbi)  fbi_q  <= bus_wdata[FBI_W-1:0];
      if (hit_fbf)  fbf_q  <= bus_wdata[FBF_W-1:0];
      if (hit_div)  div_q  <= bus_wdata;
    end
  end

  pll_lock_model #(.LOCK_CYC(LOCK_CYC)) u_lock (
    .clk(clk), .rst(rst),
    .pll_en(ctrl_q[CTRL_EN]), .bypass(ctrl_q[CTRL_BYP]),
    .restart(wr_ok && (hit_fbi || hit_fbf)),
    .lock_o(lock)
  );

  pll_outdiv_bank #(.NUM_OUT(NUM_OUT), .DIV_W(DIV_W), .PRESENT(PRESENT)) u_od (
    .clk(clk), .rst(rst),
    .wr_en(wr_ok && hit_od), .wr_idx(od_idx), .wdata(bus_wdata),
    .rd_idx(od_idx), .rd_val(od_rd)
  );

  always_comb begin
    rd_val = '0;
    if (hit_cfg)       rd_val = CFG_RESET;
    else if (hit_ctrl) rd_val = ctrl_q;
    else if (hit_stat) rd_val = {31'b0, lock};
    else if (hit_fbi)  rd_val = 32'(fbi_q);
    else if (hit_fbf)  rd_val = 32'(fbf_q);
    else if (hit_div)  rd_val = div_q;
    else if (hit_od)   rd_val = od_rd;
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_re) rdata_q <= rd_val;
    else             rdata_q <= '0;
  end

  assign bus_rdata = rdata_q;

  p_shut_ctrl_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_we && hit_ctrl && !open) |=> $stable(ctrl_q));

  p_ctrl_masked_r4: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q & ~CTRL_MASK) == 32'h0);

  p_cfg_read_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_re && hit_cfg) |=> bus_rdata == CFG_RESET);

  p_rdata_idle_r12: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> bus_rdata == 32'h0);
endmodule

// File: tb/sim_pll_ctl_regs.sv
module sim_pll_ctl_regs;
  localparam int L = 8;
  localparam logic [31:0] CFG = 32'h00A5_0000;
  localparam int DIVW = 6;
  localparam logic [31:0] ODM = 32'h0000_803F;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic we = 1'b0, re = 1'b0;
  logic [31:0] rdata;

  int checks = 0, fails = 0;
  logic [31:0] got;

  logic [31:0] m_ctrl, m_fbi, m_fbf, m_div;
  logic [31:0] m_od [16];
  bit m_open;

  always #10 clk = ~clk;

  pll_ctl_regs #(.ADDR_W(8), .NUM_OUT(16), .DIV_W(DIVW), .LOCK_CYC(L), .CFG_RESET(CFG)) u0 (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wdata(wdata),
    .bus_we(we), .bus_re(re), .bus_rdata(rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; re = 1'b1;
    @(negedge clk);
    d = rdata; re = 1'b0;
  endtask

  function automatic logic [31:0] model_read(input logic [7:0] a);
    logic [31:0] v = '0;
    if (a == 8'h08) v = CFG;
    else if (a == 8'h20) v = m_ctrl;
    else if (a == 8'h30) v = m_fbi;
    else if (a == 8'h34) v = m_fbf;
    else if (a == 8'h38) v = m_div;
    else if (a >= 8'h80 && a < 8'hC0 && a[1:0] == 2'b00) v = m_od[(a - 8'h80) >> 2];
    return v;
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [31:0] d);
    if (!m_open) return;
    if (a == 8'h20) m_ctrl = d & 32'h8000_8002;
    else if (a == 8'h30) m_fbi = d & 32'h0000_0FFF;
    else if (a == 8'h34) m_fbf = d & 32'h00FF_FFFF;
    else if (a == 8'h38) m_div = d;
    else if (a >= 8'h80 && a < 8'hC0 && a[1:0] == 2'b00) begin
      if (CFG[16 + ((a - 8'h80) >> 2)]) m_od[(a - 8'h80) >> 2] = d & ODM;
    end
  endtask

  task automatic unlock();
    wr(8'h10, 32'h68EF_3490);
    wr(8'h14, 32'hD172_BC5A);
    m_open = 1;
  endtask

  // after a trigger write, poll status one read per cycle (R9 timing)
  task automatic poll_lock(input string tag);
    for (int k = 1; k <= L + 1; k++) begin
      rd(8'h24, got);
      if (k == L)     check({tag, " status at E0+L"}, got, 32'h0);
      if (k == L + 1) check({tag, " status at E0+L+1"}, got, 32'h1);
    end
  endtask

  initial begin
    int unsigned r;
    logic [7:0] a;
    logic [31:0] d;
    m_ctrl = 32'h8000_0000; m_fbi = 0; m_fbf = 0; m_div = 0; m_open = 0;
    for (int i = 0; i < 16; i++) m_od[i] = 0;
    r = $urandom(32'h0000_5EED);
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset values
    rd(8'h20, got); check("R1 ctrl reset", got, 32'h8000_0000);
    rd(8'h24, got); check("R1 status reset", got, 32'h0);
    rd(8'h30, got); check("R1 fbi reset", got, 32'h0);
    rd(8'h38, got); check("R1 div reset", got, 32'h0);
    rd(8'h80, got); check("R1 od0 reset", got, 32'h0);
    // R6 cfg
    rd(8'h08, got); check("R6 cfg value", got, CFG);

    // R2 protected writes dropped
    wr(8'h30, 32'h0000_0123);
    rd(8'h30, got); check("R2 fbi write dropped while shut", got, 32'h0);
    // R3 second key alone
    wr(8'h14, 32'hD172_BC5A);
    wr(8'h30, 32'h0000_0124);
    rd(8'h30, got); check("R3 key B alone no unlock", got, 32'h0);
    // R3 wrong order
    wr(8'h14, 32'hD172_BC5A); wr(8'h10, 32'h68EF_3490);
    wr(8'h30, 32'h0000_0125);
    rd(8'h30, got); check("R3 reversed keys no unlock", got, 32'h0);
    // R3 bad second key after good first
    wr(8'h10, 32'h68EF_3490); wr(8'h14, 32'h1234_5678); wr(8'h14, 32'hD172_BC5A);
    wr(8'h30, 32'h0000_0126);
    rd(8'h30, got); check("R3 bad key B resets progress", got, 32'h0);
    // R2 good unlock
    unlock();
    wr(8'h30, 32'hFFFF_F456); m_fbi = 32'h456;
    rd(8'h30, got); check("R2 write after unlock", got, 32'h0000_0456);
    // R8 keys read zero
    rd(8'h10, got); check("R8 key A reads zero", got, 32'h0);
    rd(8'h14, got); check("R8 key B reads zero", got, 32'h0);
    // R3 key A again while open stays open
    wr(8'h10, 32'h68EF_3490);
    wr(8'h34, 32'hAB12_3456); m_fbf = 32'h0012_3456;
    rd(8'h34, got); check("R3 key A while open keeps open", got, 32'h0012_3456);
    // R4 ctrl mask
    wr(8'h20, 32'h7FFF_7FFD); m_ctrl = 32'h0;
    rd(8'h20, got); check("R4 ctrl masked bits", got, 32'h0);
    wr(8'h20, 32'hFFFF_FFFF); m_ctrl = 32'h8000_8002;
    rd(8'h20, got); check("R4 ctrl kept bits", got, 32'h8000_8002);
    // R5 div full width
    wr(8'h38, 32'hDEAD_BEEF); m_div = 32'hDEAD_BEEF;
    rd(8'h38, got); check("R5 div full word", got, 32'hDEAD_BEEF);
    // R6 cfg read-only
    wr(8'h08, 32'h0000_0000);
    rd(8'h08, got); check("R6 cfg write ignored", got, CFG);
    // R7 present / absent
    wr(8'h88, 32'hFFFF_FFFF); m_od[2] = ODM;
    rd(8'h88, got); check("R7 od2 present masked", got, ODM);
    wr(8'h84, 32'hFFFF_FFFF);
    rd(8'h84, got); check("R7 od1 absent reads zero", got, 32'h0);
    // R8 unmapped
    rd(8'h04, got); check("R8 unmapped 0x04", got, 32'h0);
    rd(8'h8A, got); check("R8 unaligned 0x8A", got, 32'h0);
    rd(8'hC0, got); check("R8 past od range", got, 32'h0);

    // R9 lock timing
    wr(8'h20, 32'h0000_8000); m_ctrl = 32'h0000_8000;
    poll_lock("R9 enable");
    // R10 drop on bypass
    wr(8'h20, 32'h8000_8000);
    rd(8'h24, got); check("R10 bypass drops lock", got, 32'h0);
    wr(8'h20, 32'h0000_8000);
    poll_lock("R10 re-enable");
    wr(8'h20, 32'h0000_0000);
    rd(8'h24, got); check("R10 disable drops lock", got, 32'h0);
    wr(8'h20, 32'h0000_8000);
    poll_lock("R10 second re-enable");
    // R11 fb write restarts
    wr(8'h34, 32'h0000_0077); m_fbf = 32'h77;
    poll_lock("R11 frac write");
    wr(8'h30, 32'h0000_0010); m_fbi = 32'h10;
    poll_lock("R11 int write");
    wr(8'h10, 32'h0); m_open = 0;
    wr(8'h30, 32'h0000_0999);
    rd(8'h24, got); check("R11 dropped write keeps lock", got, 32'h1);
    rd(8'h30, got); check("R11 dropped write value", got, 32'h10);
    // R12 idle read data
    @(negedge clk);
    check("R12 rdata zero when idle", rdata, 32'h0);
    unlock();

    // random stream, R5 R7 R8 R4
    for (int n = 0; n < 400; n++) begin
      r = $urandom % 24;
      case (r)
        0: a = 8'h08; 1: a = 8'h20; 2: a = 8'h30; 3: a = 8'h34; 4: a = 8'h38;
        5: a = 8'h04; 6: a = 8'h40; 7: a = 8'hC4;
        default: a = 8'h80 + 8'((r - 8) * 4);
      endcase
      d = $urandom;
      if ($urandom % 2 == 0) begin
        wr(a, d); model_write(a, d);
      end
      rd(a, got);
      check($sformatf("R5 R7 random read-back at %02h", a), got, model_read(a));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule